// File: doc/BRIEF.md
# Guarded SPI Register Port

This block is a serial slave that lets a host processor read and write a 16-bit control word and read an 8-bit diagnostic word. Every transfer begins with an 8-bit command byte, shifted in most significant bit first; depending on the command, 16 control bits follow from the host, or the slave returns 16 control bits or 8 diagnostic bits. Both clock polarities in common use are accepted: clock idling low with sampling on the rising edge (mode 0), and clock idling high with sampling on the rising edge (mode 3).

Writing the control word is guarded by an enable latch. The host sets the latch with one command, may clear it with another, and a committed write clears it again, so each write needs its own arm step. The serial clock, select and data input are brought into the system clock domain through synchronisers, and all framing is done with edge events in that domain. The data output comes with a separate drive enable so that several slaves can share one return line.

The decoded control word goes to the neighbouring regulator and driver control logic, together with a one-cycle strobe that tells the diagnostic controller its result has been read.

Top module: `spi_regif`

## Requirements
- R1: After reset the control word is 0x0000, the enable latch is clear and the data output is not driven (miso_oe low).
- R2: Command and data bits are taken from mosi on rising sck edges and returned on miso, updated after falling sck edges, most significant bit first, both with sck idling low (mode 0) and with sck idling high (mode 3).
- R3: Command 0x02 followed by 16 data bits (bit 15 first) replaces the control word when the frame ends, provided the enable latch was set when the command byte completed.
- R4: A 0x02 frame received while the enable latch is clear leaves the control word unchanged.
- R5: Command 0x06 sets the enable latch and command 0x04 clears it; after either, every further bit in the same frame is ignored until select is released.
- R6: A committed write clears the enable latch, so a second write without a new 0x06 is dropped.
- R7: A 0x02 frame that ends before all 16 data bits arrive is discarded and leaves the enable latch set.
- R8: Command 0x03 returns the 16-bit control word; only bits 15, 14, 13, 9, 8, 1 and 0 are stored (mask 0xE303) and all other bits read as 0.
- R9: Command 0x05 returns the 8 diagnostic input bits (bit 7 first), pulses diag_rd_strobe for one system clock and clears control bit 0 (start-diagnostic).
- R10: Any other command byte returns only zeros on miso and changes no state until select is released.
- R11: miso_oe is low whenever cs_n has been high for three system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the sck rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Drive enable for miso |
| diag_in | input | 8 | Diagnostic word returned by command 0x05 |
| status_o | output | 16 | Committed control word (15 REG2 on, 14 HSD1 on, 13 HSD2 on, 9 fast PWM, 8 PWM on, 1 test mode, 0 start diagnostic) |
| diag_rd_strobe | output | 1 | One-cycle pulse when the diagnostic word is read |

## Verification
The bench builds the block with its default parameters: a 16-bit control word, an 8-bit diagnostic word, two synchroniser stages and the 0xE303 storage mask. It runs the serial clock at one sixteenth of the system clock, which leaves room for the synchroniser and edge-detect latency in both clock polarities. With these values it reaches latch arming and clearing, the automatic disarm after a write, commands with trailing bits, a write cut one bit short, unknown command bytes and the start-diagnostic clear on a diagnostic read.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

   localparam int OPC_W = 8;

   localparam logic [OPC_W-1:0] OPC_WEN_SET = 8'h06;
   localparam logic [OPC_W-1:0] OPC_WEN_CLR = 8'h04;
   localparam logic [OPC_W-1:0] OPC_WR_STAT = 8'h02;
   localparam logic [OPC_W-1:0] OPC_RD_DIAG = 8'h05;
   localparam logic [OPC_W-1:0] OPC_RD_STAT = 8'h03;

   localparam int START_DIAG_BIT = 0;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_OPC,
      PH_WDATA,
      PH_WFULL,
      PH_RDATA,
      PH_HOLD
   } phase_t;

endpackage

// File: rtl/spi_regif_sync.sv
module spi_regif_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   input  logic cs_n_i,
   input  logic mosi_i,
   output logic sck_rise,
   output logic sck_fall,
   output logic cs_fall,
   output logic cs_rise,
   output logic cs_active,
   output logic mosi_s
);
   localparam int NSIG = 3;
   localparam logic [NSIG-1:0] RST_VAL = 3'b010;

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_regif_sync: STAGES must be at least 2");
   end

   logic [NSIG-1:0] raw;
   logic [NSIG-1:0] synced;
   assign raw = {mosi_i, cs_n_i, sck_i};

   for (genvar g = 0; g < NSIG; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
         else        chain <= {chain[STAGES-2:0], raw[g]};
      end
      assign synced[g] = chain[STAGES-1];
   end

   logic sck_d, cs_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         cs_d  <= 1'b1;
      end else begin
         sck_d <= synced[0];
         cs_d  <= synced[1];
      end
   end

   assign sck_rise  =  synced[0] & ~sck_d;
   assign sck_fall  = ~synced[0] &  sck_d;
   assign cs_fall   = ~synced[1] &  cs_d;
   assign cs_rise   =  synced[1] & ~cs_d;
   assign cs_active = ~synced[1];
   assign mosi_s    =  synced[2];
endmodule

// File: rtl/spi_regif_txsh.sv
module spi_regif_txsh #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] val,
   input  logic         shift,
   output logic         bit_o
);
   logic [W-1:0] sh_q;
   logic         bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         bit_q <= 1'b0;
      end else if (clr) begin
         sh_q  <= '0;
         bit_q <= 1'b0;
      end else if (load) begin
         sh_q  <= val;
      end else if (shift) begin
         bit_q <= sh_q[W-1];
         sh_q  <= {sh_q[W-2:0], 1'b0};
      end
   end

   assign bit_o = bit_q;
endmodule

// File: rtl/spi_regif_ctrl.sv
module spi_regif_ctrl
   import spi_regif_pkg::*;
#(
   parameter int                STAT_W    = 16,
   parameter int                DIAG_W    = 8,
   parameter logic [STAT_W-1:0] KEEP_MASK = 16'hE303
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              cs_fall,
   input  logic              cs_rise,
   input  logic              mosi_s,
   input  logic [DIAG_W-1:0] diag_in,
   output logic [STAT_W-1:0] status_o,
   output logic              tx_load,
   output logic [STAT_W-1:0] tx_val,
   output logic              tx_shift,
   output logic              diag_rd_strobe,
   output logic              wel_o,
   output logic              commit_o
);
   localparam int CNT_W = $clog2(STAT_W + 1);
   localparam int PAD_W = STAT_W - DIAG_W;

   if (STAT_W < OPC_W || STAT_W < DIAG_W + 1) begin : g_bad_width
      $error("spi_regif_ctrl: STAT_W must cover the opcode and exceed DIAG_W");
   end

   phase_t            phase_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [STAT_W-1:0] rx_q, pend_q, stat_q;
   logic              wel_q, strobe_q;

   logic [OPC_W-1:0]  opc_nxt;
   logic [STAT_W-1:0] data_nxt;
   logic              opc_done, rd_stat_hit, rd_diag_hit;

   assign opc_nxt     = {rx_q[OPC_W-2:0], mosi_s};
   assign data_nxt    = {rx_q[STAT_W-2:0], mosi_s};
   assign opc_done    = sck_rise && (phase_q == PH_OPC) && (cnt_q == CNT_W'(OPC_W - 1));
   assign rd_stat_hit = opc_done && (opc_nxt == OPC_RD_STAT);
   assign rd_diag_hit = opc_done && (opc_nxt == OPC_RD_DIAG);

   assign tx_load  = rd_stat_hit | rd_diag_hit;
   assign tx_val   = rd_diag_hit ? {diag_in, {PAD_W{1'b0}}} : stat_q;
   assign tx_shift = sck_fall && (phase_q == PH_RDATA);
   assign commit_o = cs_rise && (phase_q == PH_WFULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         cnt_q    <= '0;
         rx_q     <= '0;
         pend_q   <= '0;
         stat_q   <= '0;
         wel_q    <= 1'b0;
         strobe_q <= 1'b0;
      end else begin
         strobe_q <= rd_diag_hit;
         if (cs_fall) begin
            phase_q <= PH_OPC;
            cnt_q   <= '0;
         end else if (cs_rise) begin
            if (commit_o) begin
               stat_q <= pend_q & KEEP_MASK;
               wel_q  <= 1'b0;
            end
            phase_q <= PH_IDLE;
         end else if (sck_rise) begin
            rx_q <= data_nxt;
            case (phase_q)
               PH_OPC: begin
                  if (cnt_q == CNT_W'(OPC_W - 1)) begin
                     cnt_q <= '0;
                     case (opc_nxt)
                        OPC_WEN_SET: begin
                           wel_q   <= 1'b1;
                           phase_q <= PH_HOLD;
                        end
                        OPC_WEN_CLR: begin
                           wel_q   <= 1'b0;
                           phase_q <= PH_HOLD;
                        end
                        OPC_WR_STAT: phase_q <= wel_q ? PH_WDATA : PH_HOLD;
                        OPC_RD_STAT: phase_q <= PH_RDATA;
                        OPC_RD_DIAG: begin
                           stat_q[START_DIAG_BIT] <= 1'b0;
                           phase_q <= PH_RDATA;
                        end
                        default:     phase_q <= PH_HOLD;
                     endcase
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               PH_WDATA: begin
                  if (cnt_q == CNT_W'(STAT_W - 1)) begin
                     pend_q  <= data_nxt;
                     phase_q <= PH_WFULL;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign status_o       = stat_q;
   assign diag_rd_strobe = strobe_q;
   assign wel_o          = wel_q;
endmodule

// File: rtl/spi_regif.sv
module spi_regif #(
   parameter int                STAT_W      = 16,
   parameter int                DIAG_W      = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [STAT_W-1:0] KEEP_MASK   = 16'hE303
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              cs_n,
   input  logic              mosi,
   output logic              miso,
   output logic              miso_oe,
   input  logic [DIAG_W-1:0] diag_in,
   output logic [STAT_W-1:0] status_o,
   output logic              diag_rd_strobe
);
   logic sck_rise, sck_fall, cs_fall, cs_rise, cs_active, mosi_s;
   logic tx_load, tx_shift, wel_q, commit_w;
   logic [STAT_W-1:0] tx_val;

   spi_regif_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .sck_i(sck), .cs_n_i(cs_n), .mosi_i(mosi),
      .sck_rise(sck_rise), .sck_fall(sck_fall),
      .cs_fall(cs_fall), .cs_rise(cs_rise),
      .cs_active(cs_active), .mosi_s(mosi_s)
   );

   spi_regif_ctrl #(.STAT_W(STAT_W), .DIAG_W(DIAG_W), .KEEP_MASK(KEEP_MASK)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .sck_rise(sck_rise), .sck_fall(sck_fall),
      .cs_fall(cs_fall), .cs_rise(cs_rise), .mosi_s(mosi_s),
      .diag_in(diag_in), .status_o(status_o),
      .tx_load(tx_load), .tx_val(tx_val), .tx_shift(tx_shift),
      .diag_rd_strobe(diag_rd_strobe), .wel_o(wel_q), .commit_o(commit_w)
   );

   spi_regif_txsh #(.W(STAT_W)) u_txsh (
      .clk(clk), .rst_n(rst_n),
      .clr(cs_fall), .load(tx_load), .val(tx_val), .shift(tx_shift),
      .bit_o(miso)
   );

   assign miso_oe = cs_active;
endmodule

// File: rtl/spi_regif_chk.sv
module spi_regif_chk #(
   parameter int                STAT_W    = 16,
   parameter logic [STAT_W-1:0] KEEP_MASK = 16'hE303
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              miso_oe,
   input logic [STAT_W-1:0] status_o,
   input logic              diag_rd_strobe,
   input logic              wel,
   input logic              commit
);
   p_hiz_deselect_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso_oe);

   p_stat_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(status_o) |-> ($past(commit) || diag_rd_strobe));

   p_wel_autoclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !wel);

   p_strobe_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      diag_rd_strobe |=> !diag_rd_strobe);

   p_start_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      diag_rd_strobe |-> !status_o[0]);

   p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o & ~KEEP_MASK) == '0);
endmodule

bind spi_regif spi_regif_chk #(.STAT_W(STAT_W), .KEEP_MASK(KEEP_MASK)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso_oe(miso_oe),
   .status_o(status_o), .diag_rd_strobe(diag_rd_strobe),
   .wel(wel_q), .commit(commit_w)
);

// File: tb/spi_regif_bench.sv
module spi_regif_bench;
   localparam int CLK_NS = 10;
   localparam int HALF   = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0;
   logic        cs_n = 1'b1;
   logic        mosi = 1'b0;
   logic        miso, miso_oe;
   logic [7:0]  diag_in = 8'h00;
   logic [15:0] status_o;
   logic        diag_rd_strobe;

   int n_chk = 0;
   int n_bad = 0;
   int n_strobe = 0;

   always #(CLK_NS / 2) clk = ~clk;

   spi_regif u_spi_regif (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
      .miso(miso), .miso_oe(miso_oe), .diag_in(diag_in),
      .status_o(status_o), .diag_rd_strobe(diag_rd_strobe)
   );

   always @(posedge clk) if (rst_n && diag_rd_strobe) n_strobe++;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic xfer(input logic cpol, input logic [31:0] tx, input int nbits,
                       output logic [31:0] rx);
      rx = '0;
      @(negedge clk);
      sck = cpol;
      repeat (4) @(negedge clk);
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = nbits - 1; i >= 0; i--) begin
         mosi = tx[i];
         sck  = 1'b0;
         repeat (HALF) @(negedge clk);
         rx   = {rx[30:0], miso};
         sck  = 1'b1;
         repeat (HALF) @(negedge clk);
      end
      cs_n = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = cpol;
      repeat (4) @(negedge clk);
   endtask

   task automatic arm(input logic cpol);
      logic [31:0] rx;
      xfer(cpol, 32'h06, 8, rx);
   endtask

   task automatic write_stat(input logic cpol, input logic [15:0] v);
      logic [31:0] rx;
      xfer(cpol, {8'h0, 8'h02, v}, 24, rx);
   endtask

   task automatic read_stat(input logic cpol, output logic [15:0] v);
      logic [31:0] rx;
      xfer(cpol, 32'h03 << 16, 24, rx);
      v = rx[15:0];
   endtask

   task automatic t_reset();
      chk("R1 status after reset", {16'h0, status_o}, 32'h0000);
      chk("R1 miso_oe after reset", {31'h0, miso_oe}, 32'h0);
      write_stat(1'b0, 16'h8000);
      chk("R1 latch clear after reset", {16'h0, status_o}, 32'h0000);
   endtask

   task automatic t_write_read();
      logic [15:0] v;
      arm(1'b0);
      write_stat(1'b0, 16'hA5C3);
      chk("R3 R8 masked write mode0", {16'h0, status_o}, 32'hA103);
      read_stat(1'b1, v);
      chk("R2 R8 read mode3", {16'h0, v}, 32'hA103);
      read_stat(1'b0, v);
      chk("R2 read mode0", {16'h0, v}, 32'hA103);
   endtask

   task automatic t_wel_auto();
      arm(1'b1);
      write_stat(1'b1, 16'h0001);
      chk("R3 write mode3", {16'h0, status_o}, 32'h0001);
      write_stat(1'b1, 16'hE302);
      chk("R6 second write dropped", {16'h0, status_o}, 32'h0001);
   endtask

   task automatic t_wel_clr();
      logic [31:0] rx;
      arm(1'b0);
      xfer(1'b0, 32'h04, 8, rx);
      write_stat(1'b0, 16'hFFFF);
      chk("R5 R4 write after clear dropped", {16'h0, status_o}, 32'h0001);
   endtask

   task automatic t_tail();
      logic [31:0] rx;
      xfer(1'b0, {8'h06, 8'h02, 16'h8000}, 32, rx);
      chk("R5 trailing bits ignored", {16'h0, status_o}, 32'h0001);
      write_stat(1'b0, 16'h8000);
      chk("R5 latch set by tail frame", {16'h0, status_o}, 32'h8000);
   endtask

   task automatic t_trunc();
      logic [31:0] rx;
      arm(1'b0);
      xfer(1'b0, (32'h02 << 15) | 32'h7181, 23, rx);
      chk("R7 short frame discarded", {16'h0, status_o}, 32'h8000);
      write_stat(1'b0, 16'h0200);
      chk("R7 latch kept after short frame", {16'h0, status_o}, 32'h0200);
   endtask

   task automatic t_unknown();
      logic [31:0] rx;
      xfer(1'b0, {8'h0, 8'h07, 16'hFFFF}, 24, rx);
      chk("R10 unknown 0x07 miso zero", rx, 32'h0);
      xfer(1'b1, {8'h0, 8'hFF, 16'hFFFF}, 24, rx);
      chk("R10 unknown 0xFF miso zero", rx, 32'h0);
      chk("R10 status unchanged", {16'h0, status_o}, 32'h0200);
   endtask

   task automatic t_diag();
      logic [31:0] rx;
      int s0;
      arm(1'b0);
      write_stat(1'b0, 16'h0003);
      chk("R3 start-diag set", {16'h0, status_o}, 32'h0003);
      diag_in = 8'h96;
      s0 = n_strobe;
      xfer(1'b0, 32'h0500, 16, rx);
      chk("R9 diag read mode0", {24'h0, rx[7:0]}, 32'h96);
      chk("R9 one strobe", s0 + 1, n_strobe);
      chk("R9 start-diag cleared", {16'h0, status_o}, 32'h0002);
      diag_in = 8'h3C;
      xfer(1'b1, 32'h0500, 16, rx);
      chk("R9 R2 diag read mode3", {24'h0, rx[7:0]}, 32'h3C);
      chk("R9 second strobe", s0 + 2, n_strobe);
   endtask

   task automatic t_hiz();
      @(negedge clk);
      cs_n = 1'b0;
      repeat (6) @(negedge clk);
      chk("R11 driven while selected", {31'h0, miso_oe}, 32'h1);
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
      chk("R11 released when deselected", {31'h0, miso_oe}, 32'h0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_write_read();
      t_wel_auto();
      t_wel_clr();
      t_tail();
      t_trunc();
      t_unknown();
      t_diag();
      t_hiz();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule